// File: doc/BRIEF.md
# Extended Compare and Count ALU

This block is a purely combinational 64-bit execution unit that serves a handful of extra integer instructions. These instructions sit in an already-routed secondary opcode space. The caller has done the major-opcode decode and has read both source registers. It presents the low 21 bits of the instruction word and the two operand values. In the same cycle the block returns a result, the index of the register to write, a write enable and a reserved-instruction flag.

The supported operations are:
- a sum of both operands that wraps at 8 bits;
- register-register equality and inequality sets;
- equality and inequality sets against a sign-extended 10-bit immediate;
- a population count over either the low half or the whole of the first operand.

Any function code outside this set is reported as reserved and writes nothing.

Top module: `xcc_alu`

## Requirements
- R1: Function code 0x28 (insn[5:0]) gives result = (rs_val + rt_val) mod 256, zero-extended to 64 bits, with dest_idx = insn[15:11] and wr_en = 1.
- R2: Function code 0x2a gives result 1 when rs_val equals rt_val and 0 otherwise, with dest_idx = insn[15:11].
- R3: Function code 0x2b gives result 0 when rs_val equals rt_val and 1 otherwise, with dest_idx = insn[15:11].
- R4: Function code 0x2e sign-extends the immediate insn[15:6] to 64 bits. It gives result 1 when rs_val equals that value and 0 otherwise, with dest_idx = insn[20:16].
- R5: Function code 0x2f gives the inverse of the R4 comparison, using the same sign-extended immediate, with dest_idx = insn[20:16].
- R6: Function code 0x2c gives the number of set bits in rs_val[31:0]. Bits 63:32 have no effect. dest_idx = insn[15:11].
- R7: Function code 0x2d gives the number of set bits in all 64 bits of rs_val, with dest_idx = insn[15:11].
- R8: Any other function code gives rsvd_insn = 1, wr_en = 0, result = 0 and dest_idx = 0.
- R9: Every function code listed in R1 to R7 gives rsvd_insn = 0 and wr_en = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 21 | Instruction bits 20:0: target field 20:16, dest field 15:11, immediate 15:6, function 5:0 |
| rs_val | input | 64 | First source operand value |
| rt_val | input | 64 | Second source operand value |
| result | output | 64 | Value to be written back |
| dest_idx | output | 5 | Register index to be written |
| wr_en | output | 1 | Register write request |
| rsvd_insn | output | 1 | Function code is not implemented |

## Verification
The checks evaluate the outputs combinationally whenever the inputs change. They assume the three inputs carry fully known values, and they skip any evaluation in which an input is still unknown. They also assume that insn carries only the fields listed in the port table. The bench drives defined values onto every input from the first edge onward and holds each instruction for a full cycle. It reads the outputs mid-cycle, well away from the input changes. It sweeps all 64 function codes against mixed operand patterns, including equal operands and operands that match the immediate.

// File: rtl/xcc_alu_pkg.sv
// Shared types for the extended compare and count ALU.
// Assumes one decoded operation per instruction; no state.
package xcc_alu_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_BADD  = 3'd1,
        OP_EQR   = 3'd2,
        OP_NER   = 3'd3,
        OP_EQI   = 3'd4,
        OP_NEI   = 3'd5,
        OP_CNT32 = 3'd6,
        OP_CNT64 = 3'd7
    } xcc_op_e;

    localparam logic [5:0] FN_BADD  = 6'h28;
    localparam logic [5:0] FN_EQR   = 6'h2a;
    localparam logic [5:0] FN_NER   = 6'h2b;
    localparam logic [5:0] FN_CNT32 = 6'h2c;
    localparam logic [5:0] FN_CNT64 = 6'h2d;
    localparam logic [5:0] FN_EQI   = 6'h2e;
    localparam logic [5:0] FN_NEI   = 6'h2f;
endpackage

// File: rtl/xcc_alu_decode.sv
// Function-code decoder: maps the 6-bit code to an operation.
// It also chooses whether the target field or the dest field names the register to write.
// Assumes the caller has already routed only this opcode space here.
module xcc_alu_decode
    import xcc_alu_pkg::*;
(
    input  logic [5:0] fn,
    output xcc_op_e    op,
    output logic       use_rt_dest,
    output logic       wr_en,
    output logic       rsvd
);
    // Translate the function code into operation, destination choice and validity.
    always_comb begin
        op          = OP_NONE;
        use_rt_dest = 1'b0;
        wr_en       = 1'b1;
        rsvd        = 1'b0;
        unique case (fn)
            FN_BADD:  op = OP_BADD;
            FN_EQR:   op = OP_EQR;
            FN_NER:   op = OP_NER;
            FN_EQI:   begin op = OP_EQI; use_rt_dest = 1'b1; end
            FN_NEI:   begin op = OP_NEI; use_rt_dest = 1'b1; end
            FN_CNT32: op = OP_CNT32;
            FN_CNT64: op = OP_CNT64;
            default:  begin wr_en = 1'b0; rsvd = 1'b1; end
        endcase
    end
endmodule

// File: rtl/xcc_alu_eqz.sv
// Equality detector: exclusive-OR of the operands followed by a zero test.
// Assumes both operands have the same width W.
module xcc_alu_eqz #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] diff;

    // Bitwise difference, then reduce to a single zero flag.
    always_comb begin
        diff = a ^ b;
        eq   = ~|diff;
    end
endmodule

// File: rtl/xcc_alu_popcnt.sv
// Population counter with a selectable active width.
// When narrow is set, bits at or above HALF are masked off before counting.
// Assumes HALF <= W.
module xcc_alu_popcnt #(
    parameter int W    = 64,
    parameter int HALF = 32,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    input  logic          narrow,
    output logic [CW-1:0] count
);
    logic [W-1:0] keep;
    logic [W-1:0] masked;

    // Per-bit keep mask: lower half always counted, upper half only in wide mode.
    for (genvar g = 0; g < W; g++) begin : g_mask
        if (g < HALF) begin : g_lo
            assign keep[g] = 1'b1;
        end else begin : g_hi
            assign keep[g] = ~narrow;
        end
    end

    assign masked = vec & keep;

    // Sum the surviving bits.
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(masked[i]);
        end
    end
endmodule

// File: rtl/xcc_alu.sv
// Extended compare and count ALU, top level.
// Combinational: it decodes the function field, selects a result and names a destination register.
// Assumes insn holds instruction bits 20:0 and that the operands are already read.
module xcc_alu
    import xcc_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int HALF   = 32,
    parameter int IMMW   = 10,
    parameter int BYTEW  = 8,
    parameter int REGW   = 5,
    localparam int INSNW = 16 + REGW,
    localparam int CW    = $clog2(XLEN + 1)
) (
    input  logic [INSNW-1:0] insn,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output logic [XLEN-1:0]  result,
    output logic [REGW-1:0]  dest_idx,
    output logic             wr_en,
    output logic             rsvd_insn
);
    logic [5:0]      fn;
    logic [REGW-1:0] rt_idx;
    logic [REGW-1:0] rd_idx;
    logic [IMMW-1:0] imm;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] sum;
    xcc_op_e         op;
    logic            use_rt_dest;
    logic            eq_reg;
    logic            eq_imm;
    logic [CW-1:0]   bits_set;

    // Split the instruction into its fields.
    always_comb begin
        fn      = insn[5:0];
        imm     = insn[15:6];
        rd_idx  = insn[15:11];
        rt_idx  = insn[INSNW-1:16];
        imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        sum     = rs_val + rt_val;
    end

    xcc_alu_decode u_dec (
        .fn          (fn),
        .op          (op),
        .use_rt_dest (use_rt_dest),
        .wr_en       (wr_en),
        .rsvd        (rsvd_insn)
    );

    xcc_alu_eqz #(.W(XLEN)) u_eq_reg (
        .a  (rs_val),
        .b  (rt_val),
        .eq (eq_reg)
    );

    xcc_alu_eqz #(.W(XLEN)) u_eq_imm (
        .a  (rs_val),
        .b  (imm_ext),
        .eq (eq_imm)
    );

    xcc_alu_popcnt #(.W(XLEN), .HALF(HALF)) u_cnt (
        .vec    (rs_val),
        .narrow (op == OP_CNT32),
        .count  (bits_set)
    );

    // Choose the result for the decoded operation.
    always_comb begin
        result = '0;
        unique case (op)
            OP_BADD:  result = {{(XLEN-BYTEW){1'b0}}, sum[BYTEW-1:0]};
            OP_EQR:   result = {{(XLEN-1){1'b0}}, eq_reg};
            OP_NER:   result = {{(XLEN-1){1'b0}}, ~eq_reg};
            OP_EQI:   result = {{(XLEN-1){1'b0}}, eq_imm};
            OP_NEI:   result = {{(XLEN-1){1'b0}}, ~eq_imm};
            OP_CNT32,
            OP_CNT64: result = {{(XLEN-CW){1'b0}}, bits_set};
            default:  result = '0;
        endcase
    end

    // Pick the destination register; none is named when the code is reserved.
    always_comb begin
        if (rsvd_insn)
            dest_idx = '0;
        else if (use_rt_dest)
            dest_idx = rt_idx;
        else
            dest_idx = rd_idx;
    end
endmodule

// File: rtl/xcc_alu_chk.sv
// Checker for xcc_alu: combinational properties evaluated whenever the inputs are known.
// Assumes fully known inputs; an evaluation with unknown inputs is skipped.
module xcc_alu_chk (
    input logic [20:0] insn,
    input logic [63:0] rs_val,
    input logic [63:0] rt_val,
    input logic [63:0] result,
    input logic [4:0]  dest_idx,
    input logic        wr_en,
    input logic        rsvd_insn
);
    logic known;
    logic is_set;
    logic [7:0] low_sum;

    // Gate every check on known inputs.
    always_comb begin
        known   = !$isunknown({insn, rs_val, rt_val});
        is_set  = (insn[5:0] == 6'h2a) || (insn[5:0] == 6'h2b) ||
                  (insn[5:0] == 6'h2e) || (insn[5:0] == 6'h2f);
        low_sum = rs_val[7:0] + rt_val[7:0];
    end

    // Combinational property checks.
    always_comb begin
        if (known) begin
            p_write_xor_rsvd_r9: assert (wr_en != rsvd_insn);
            p_rsvd_quiet_r8: assert (!rsvd_insn || (result == 64'd0 && dest_idx == 5'd0));
            p_byte_sum_r1: assert (insn[5:0] != 6'h28 || result == {56'd0, low_sum});
            p_set_boolean_r2: assert (!is_set || result[63:1] == 63'd0);
            p_eq_reg_r2: assert (insn[5:0] != 6'h2a || result[0] == (rs_val == rt_val));
            p_ne_reg_r3: assert (insn[5:0] != 6'h2b || result[0] == (rs_val != rt_val));
            p_imm_dest_r4: assert (!(insn[5:0] == 6'h2e || insn[5:0] == 6'h2f) ||
                                   dest_idx == insn[20:16]);
            p_pop_bound_r6: assert (insn[5:0] != 6'h2c || result <= 64'd32);
            p_dpop_bound_r7: assert (insn[5:0] != 6'h2d || result <= 64'd64);
        end
    end
endmodule

bind xcc_alu xcc_alu_chk u_chk (
    .insn      (insn),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .result    (result),
    .dest_idx  (dest_idx),
    .wr_en     (wr_en),
    .rsvd_insn (rsvd_insn)
);

// File: tb/xcc_alu_tb.sv
// Bench for xcc_alu: sweeps every function code over mixed operands.
// Expected values come from an arithmetic model written from the requirements.
module xcc_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] insn = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] rt_val = '0;
    logic [63:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        rsvd_insn;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [63:0] seed = 64'h9e37_79b9_7f4a_7c15;

    always #4 clk = ~clk;

    xcc_alu u_dut (
        .insn      (insn),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .result    (result),
        .dest_idx  (dest_idx),
        .wr_en     (wr_en),
        .rsvd_insn (rsvd_insn)
    );

    // Requirement tag for a function code.
    function automatic string tag_of(input logic [5:0] f);
        case (f)
            6'h28: return "R1";
            6'h2a: return "R2";
            6'h2b: return "R3";
            6'h2e: return "R4";
            6'h2f: return "R5";
            6'h2c: return "R6";
            6'h2d: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [63:0] ones(input logic [63:0] v, input int w);
        logic [63:0] c = 0;
        for (int i = 0; i < w; i++) c = c + {63'd0, v[i]};
        return c;
    endfunction

    // Produce the next pseudo-random operand word.
    function automatic logic [63:0] nxt(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // Apply one instruction, compare the combined outputs mid-cycle.
    task automatic run(input logic [5:0] f, input logic [4:0] rt, input logic [9:0] imm,
                       input logic [63:0] a, input logic [63:0] b);
        logic [63:0] e_res;
        logic [4:0]  e_dst;
        logic        e_wr, e_rsv;
        logic [63:0] iext;
        logic [63:0] s;
        iext = {{54{imm[9]}}, imm};
        s = a + b;
        e_wr = 1'b1; e_rsv = 1'b0; e_dst = imm[9:5];
        case (f)
            6'h28: e_res = {56'd0, s[7:0]};
            6'h2a: e_res = (a == b) ? 64'd1 : 64'd0;
            6'h2b: e_res = (a != b) ? 64'd1 : 64'd0;
            6'h2e: begin e_res = (a == iext) ? 64'd1 : 64'd0; e_dst = rt; end
            6'h2f: begin e_res = (a != iext) ? 64'd1 : 64'd0; e_dst = rt; end
            6'h2c: e_res = ones(a, 32);
            6'h2d: e_res = ones(a, 64);
            default: begin e_res = 0; e_dst = 0; e_wr = 0; e_rsv = 1; end
        endcase
        @(posedge clk);
        insn = {rt, imm, f};
        rs_val = a;
        rt_val = b;
        @(negedge clk);
        n_chk++;
        if (result !== e_res || dest_idx !== e_dst || wr_en !== e_wr || rsvd_insn !== e_rsv) begin
            n_bad++;
            $display("FAIL %s%s fn=%h: got res=%h dst=%0d wr=%b rsv=%b, want res=%h dst=%0d wr=%b rsv=%b",
                     tag_of(f), e_rsv ? "" : "/R9", f, result, dest_idx, wr_en, rsvd_insn,
                     e_res, e_dst, e_wr, e_rsv);
        end
    endtask

    // Check one output value against a literal worked out by hand.
    task automatic lit(input string tag, input logic [63:0] want);
        n_chk++;
        if (result !== want) begin
            n_bad++;
            $display("FAIL %s literal: got %h want %h", tag, result, want);
        end
    endtask

    // Stimulus: reset-time state, directed corners, then the full function sweep.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rsvd_insn !== 1'b1 || wr_en !== 1'b0 || result !== 64'd0 || dest_idx !== 5'd0) begin
            n_bad++;
            $display("FAIL R8 idle: got rsv=%b wr=%b res=%h dst=%0d, want 1 0 0 0",
                     rsvd_insn, wr_en, result, dest_idx);
        end
        // R1: the sum wraps at 8 bits
        run(6'h28, 5'd3, 10'h1a0, 64'hff, 64'h1);                         lit("R1", 64'd0);
        run(6'h28, 5'd3, 10'h1a0, 64'hffff_ffff_ffff_ff80, 64'h80);       lit("R1", 64'd0);
        run(6'h28, 5'd3, 10'h1a0, 64'h1234_0000_0000_00f0, 64'h35);       lit("R1", 64'h25);
        // R2 and R3 with equal operands
        run(6'h2a, 5'd1, 10'h040, 64'hdead_beef_0000_0001, 64'hdead_beef_0000_0001); lit("R2", 64'd1);
        run(6'h2b, 5'd1, 10'h040, 64'hdead_beef_0000_0001, 64'hdead_beef_0000_0001); lit("R3", 64'd0);
        // R4: a negative immediate matches all ones; its raw 10-bit pattern does not
        run(6'h2e, 5'd9, 10'h3ff, 64'hffff_ffff_ffff_ffff, 64'd0);        lit("R4", 64'd1);
        run(6'h2e, 5'd9, 10'h3ff, 64'h3ff, 64'd0);                        lit("R4", 64'd0);
        run(6'h2e, 5'd9, 10'h1ff, 64'h1ff, 64'd0);                        lit("R4", 64'd1);
        // R5
        run(6'h2f, 5'd31, 10'h200, 64'hffff_ffff_ffff_fe00, 64'd0);       lit("R5", 64'd0);
        run(6'h2f, 5'd31, 10'h200, 64'h200, 64'd0);                       lit("R5", 64'd1);
        // R6: the upper half is ignored; R7 counts it
        run(6'h2c, 5'd2, 10'h0, 64'hffff_ffff_0000_0000, 64'd0);          lit("R6", 64'd0);
        run(6'h2c, 5'd2, 10'h0, 64'hffff_ffff_ffff_ffff, 64'd0);          lit("R6", 64'd32);
        run(6'h2d, 5'd2, 10'h0, 64'hffff_ffff_0000_0000, 64'd0);          lit("R7", 64'd32);
        run(6'h2d, 5'd2, 10'h0, 64'hffff_ffff_ffff_ffff, 64'd0);          lit("R7", 64'd64);
        // Sweep all function codes over mixed operands (R8, R9 and the rest)
        for (int f = 0; f < 64; f++) begin
            for (int k = 0; k < 16; k++) begin
                logic [63:0] a, b;
                logic [9:0]  im;
                logic [4:0]  rt;
                seed = nxt(seed); a = seed;
                seed = nxt(seed); b = seed;
                im = seed[9:0];
                rt = seed[20:16];
                if (k % 4 == 0) b = a;
                if (k % 4 == 1) a = {{54{im[9]}}, im};
                if (k == 2) a = 64'd0;
                run(f[5:0], rt, im, a, b);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule